// File: doc/BRIEF.md
# Block-Cipher Accelerator Control Register Front-End

This block is the software-facing register set of a DMA-driven block-cipher accelerator. A host reaches it over a plain 32-bit register bus. That bus has an address, a write enable, write data and combinational read data. Every write completes in the cycle it is presented, and a read returns data in the same cycle. The block stores:

- the operation setup word;
- the source, destination and two companion buffer descriptors;
- eight key words and four IV words;
- a key-type word and its complemented copy.

It decodes the setup word into key-size, chaining-mode and direction outputs that the cipher datapath uses. It also presents the key, IV and buffer descriptors to that datapath.

A write to the go register requests an operation. The request waits while the hold bit is set, and it also waits while a previous completion is still unacknowledged. When the request launches, the block checks the configuration. The key-type pair must be complementary. Both companion lengths must equal the source length, and the companion address must equal the source address. A good configuration produces a one-cycle start pulse and a busy state that lasts until the datapath reports done. A bad configuration sets an error flag and produces no start pulse.

There is no streaming data path in this block, so no valid/ready handshake appears. The start, done, error and busy signals are plain level or pulse pins.

Top module: `cipher_csr_frontend`

## Requirements
- R1: Words at byte offsets 0x00, 0x08, 0x18, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x70, 0x4C–0x6C, 0x74–0x80 and 0x88 store all 32 bits written and read them back; all reset to zero. The go word (0x04) and any offset with no storage read as zero.
- R2: Setup (0x14) bits [5:4] drive `key_size_o`: 00→0 (128-bit), 01→1 (192-bit), 10 or 11→2 (256-bit).
- R3: Setup bits [3:2] drive `mode_o`: 00 or 01→0 (ECB), 10→1 (CBC), 11→2 (CTR). Bit 0 drives `encrypt_o` (1 = encrypt). Bit 1 is stored with no effect. Bits [31:6] read back as zero.
- R4: `key_o[255:224]` is the word at 0x4C and each following word takes the next 32 bits down, so `key_o[31:0]` is 0x68 and a 128-bit key occupies `key_o[127:0]`. `iv_o[127:96]` is 0x74 and `iv_o[31:0]` is 0x80.
- R5: Only bit 0 of a go write matters. A go write with bit 0 clear never starts an operation.
- R6: A launch where the word at 0x6C is not the bitwise inverse of the word at 0x88 sets status bit 4 (error), keeps `busy_o` low and produces no `start_o` pulse.
- R7: A launch where the length at 0x2C or at 0x34 differs from the length at 0x24, or where the address at 0x30 differs from 0x28, behaves as in R6.
- R8: Offset 0x40 reads 1 when the length at 0x18 is greater than the length at 0x24, and 0 otherwise.
- R9: Status (0x0C) layout: bit 0 done, bit 1 busy, bit 2 attention, bit 3 constant 1, bit 4 error. It resets to 0x0000000C. Writing 1 to bit 0, 2 or 4 clears that bit. Bits 1, 3 and 31:5 ignore writes.
- R10: Offset 0x84 reads 0xF and ignores writes. Offsets 0x10 and 0x1C read zero and ignore writes.
- R11: While bit 0 of 0x08 is set, a pending go request does not launch. It launches after that bit is cleared.
- R12: A go write in idle launches one edge later. A valid launch gives a one-cycle `start_o` and sets `busy_o` (status bit 1) until `core_done_i` or `core_err_i`. Either of those returns the block to idle and sets done; `core_err_i` also sets error. A pending request does not launch while done is set.
- R13: A go write while busy is ignored and produces no later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| key_size_o | output | 2 | 0 = 128, 1 = 192, 2 = 256 bits |
| mode_o | output | 2 | 0 = ECB, 1 = CBC, 2 = CTR |
| encrypt_o | output | 1 | 1 = encrypt, 0 = decrypt |
| key_o | output | 256 | Key words, word at 0x4C highest |
| iv_o | output | 128 | IV words, word at 0x74 highest |
| src_addr_o | output | 32 | Source buffer address |
| src_len_o | output | 32 | Source length |
| dst_addr_o | output | 32 | Destination buffer address |
| dst_len_o | output | 32 | Destination length |
| start_o | output | 1 | One-cycle launch pulse to datapath |
| core_done_i | input | 1 | Datapath completion pulse |
| core_err_i | input | 1 | Datapath failure pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
Register writes are visible on the combinational read port one edge after the write is presented. Decode outputs follow the setup word after the same edge. A go write sets the pending request on its own edge, and the launch happens on the next edge, so `start_o`, `busy_o` and the error bit are due two edges after the go write. A hold release or done clear also takes two edges. The bench drives and samples on falling edges and checks these results exactly one falling edge after its write task returns. Datapath completion comes from a fixed-latency model, so the bench polls the done bit with a bounded wait instead of predicting that cycle.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 35;
  localparam int KEY_WORDS = 8;
  localparam int IV_WORDS  = 4;

  // word indices (byte offset / 4)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_GO    = 1;
  localparam int IDX_HOLD  = 2;
  localparam int IDX_STAT  = 3;
  localparam int IDX_SETUP = 5;
  localparam int IDX_OLEN  = 6;
  localparam int IDX_OADDR = 8;
  localparam int IDX_ILEN  = 9;
  localparam int IDX_IADDR = 10;
  localparam int IDX_XLEN  = 11;
  localparam int IDX_XADDR = 12;
  localparam int IDX_ALEN  = 13;
  localparam int IDX_CMP   = 16;
  localparam int IDX_KEY0  = 19;
  localparam int IDX_KTYPE = 27;
  localparam int IDX_OPW   = 28;
  localparam int IDX_IV0   = 29;
  localparam int IDX_FIXED = 33;
  localparam int IDX_KTINV = 34;

  typedef enum logic [1:0] {KS_128 = 2'd0, KS_192 = 2'd1, KS_256 = 2'd2} ksz_e;
  typedef enum logic [1:0] {MD_ECB = 2'd0, MD_CBC = 2'd1, MD_CTR = 2'd2} mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} st_e;

  function automatic logic [DATA_W-1:0] word_wmask(int idx);
    if (idx == IDX_SETUP) return 32'h0000_003F;
    if (idx == IDX_CTRL || idx == IDX_HOLD || idx == IDX_OLEN || idx == IDX_OADDR ||
        idx == IDX_ILEN || idx == IDX_IADDR || idx == IDX_XLEN || idx == IDX_XADDR ||
        idx == IDX_ALEN || idx == IDX_KTYPE || idx == IDX_OPW || idx == IDX_KTINV)
      return '1;
    if (idx >= IDX_KEY0 && idx < IDX_KEY0 + KEY_WORDS) return '1;
    if (idx >= IDX_IV0 && idx < IDX_IV0 + IV_WORDS) return '1;
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] word_rst(int idx);
    return (idx == IDX_FIXED) ? 32'h0000_000F : '0;
  endfunction
endpackage

// File: rtl/cfe_regfile.sv
module cfe_regfile
  import cfe_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words_o
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] words_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= word_rst(i);
    end else if (we) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (idx == IDX_W'(i))
          words_q[i] <= (words_q[i] & ~word_wmask(i)) | (wdata & word_wmask(i));
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (idx == IDX_W'(i)) rdata = words_q[i];
  end

  assign words_o = words_q;
endmodule

// File: rtl/cfe_setup_decode.sv
module cfe_setup_decode
  import cfe_pkg::*;
(
  input  logic [5:0] setup,
  output ksz_e       ksz,
  output mode_e      mode,
  output logic       encrypt
);
  always_comb begin
    unique case (setup[5:4])
      2'b00:   ksz = KS_128;
      2'b01:   ksz = KS_192;
      default: ksz = KS_256;
    endcase
    unique case (setup[3:2])
      2'b10:   mode = MD_CBC;
      2'b11:   mode = MD_CTR;
      default: mode = MD_ECB;
    endcase
    encrypt = setup[0];
  end
endmodule

// File: rtl/cfe_cfg_check.sv
module cfe_cfg_check
  import cfe_pkg::*;
(
  input  logic [DATA_W-1:0] ktype,
  input  logic [DATA_W-1:0] ktype_inv,
  input  logic [DATA_W-1:0] src_len,
  input  logic [DATA_W-1:0] src_addr,
  input  logic [DATA_W-1:0] aux_len,
  input  logic [DATA_W-1:0] aux_addr,
  input  logic [DATA_W-1:0] add_len,
  output logic              cfg_ok
);
  logic pair_ok, desc_ok;
  assign pair_ok = (ktype == ~ktype_inv);
  assign desc_ok = (aux_len == src_len) && (add_len == src_len) && (aux_addr == src_addr);
  assign cfg_ok  = pair_ok && desc_ok;
endmodule

// File: rtl/cfe_status_ctrl.sv
module cfe_status_ctrl
  import cfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_we,
  input  logic       go_bit,
  input  logic       hold,
  input  logic       cfg_ok,
  input  logic       st_we,
  input  logic [4:0] st_wdata,
  input  logic       core_done,
  input  logic       core_err,
  output logic       start_o,
  output logic       busy_o,
  output logic [4:0] status_o
);
  st_e  state_q;
  logic pend_q, start_q, done_q, attn_q, err_q;
  logic launch;

  assign launch = pend_q && !hold && !done_q && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      attn_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (st_we) begin
        if (st_wdata[0]) done_q <= 1'b0;
        if (st_wdata[2]) attn_q <= 1'b0;
        if (st_wdata[4]) err_q  <= 1'b0;
      end
      if (go_we && go_bit && state_q == ST_IDLE) pend_q <= 1'b1;
      if (launch) begin
        pend_q <= 1'b0;
        if (cfg_ok) begin
          state_q <= ST_BUSY;
          start_q <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (state_q == ST_BUSY && (core_done || core_err)) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        if (core_err) err_q <= 1'b1;
      end
    end
  end

  assign start_o  = start_q;
  assign busy_o   = (state_q == ST_BUSY);
  assign status_o = {err_q, 1'b1, attn_q, busy_o, done_q};

  // R6/R7: a start pulse only follows a launch that saw a good configuration
  assert_start_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(cfg_ok));
  assert_cfg_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !cfg_ok) |=> (err_q && !start_q && state_q == ST_IDLE));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !$past(hold));
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && go_we && !core_done && !core_err) |=>
      (state_q == ST_BUSY && !start_q && !pend_q));
endmodule

// File: rtl/cipher_csr_frontend.sv
module cipher_csr_frontend
  import cfe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [1:0]          key_size_o,
  output logic [1:0]          mode_o,
  output logic                encrypt_o,
  output logic [255:0]        key_o,
  output logic [127:0]        iv_o,
  output logic [31:0]         src_addr_o,
  output logic [31:0]         src_len_o,
  output logic [31:0]         dst_addr_o,
  output logic [31:0]         dst_len_o,
  output logic                start_o,
  input  logic                core_done_i,
  input  logic                core_err_i,
  output logic                busy_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                  idx;
  logic [DATA_W-1:0]                 rf_rdata;
  logic [NUM_WORDS-1:0][DATA_W-1:0]  words;
  logic                              cfg_ok;
  logic [4:0]                        status;
  ksz_e                              ksz;
  mode_e                             mode;

  assign idx = bus_addr[ADDR_W-1:2];

  cfe_regfile #(.IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .idx(idx),
    .wdata(bus_wdata), .rdata(rf_rdata), .words_o(words)
  );

  cfe_setup_decode u_dec (
    .setup(words[IDX_SETUP][5:0]), .ksz(ksz), .mode(mode), .encrypt(encrypt_o)
  );

  cfe_cfg_check u_chk (
    .ktype(words[IDX_KTYPE]), .ktype_inv(words[IDX_KTINV]),
    .src_len(words[IDX_ILEN]), .src_addr(words[IDX_IADDR]),
    .aux_len(words[IDX_XLEN]), .aux_addr(words[IDX_XADDR]),
    .add_len(words[IDX_ALEN]), .cfg_ok(cfg_ok)
  );

  cfe_status_ctrl u_st (
    .clk(clk), .rst_n(rst_n),
    .go_we(bus_we && idx == IDX_W'(IDX_GO)), .go_bit(bus_wdata[0]),
    .hold(words[IDX_HOLD][0]), .cfg_ok(cfg_ok),
    .st_we(bus_we && idx == IDX_W'(IDX_STAT)), .st_wdata(bus_wdata[4:0]),
    .core_done(core_done_i), .core_err(core_err_i),
    .start_o(start_o), .busy_o(busy_o), .status_o(status)
  );

  always_comb begin
    if (idx == IDX_W'(IDX_STAT))
      bus_rdata = {27'd0, status};
    else if (idx == IDX_W'(IDX_CMP))
      bus_rdata = {31'd0, (words[IDX_OLEN] > words[IDX_ILEN])};
    else
      bus_rdata = rf_rdata;
  end

  genvar k;
  generate
    for (k = 0; k < KEY_WORDS; k++) begin : g_key
      assign key_o[255 - 32*k -: 32] = words[IDX_KEY0 + k];
    end
    for (k = 0; k < IV_WORDS; k++) begin : g_iv
      assign iv_o[127 - 32*k -: 32] = words[IDX_IV0 + k];
    end
  endgenerate

  assign key_size_o = ksz;
  assign mode_o     = mode;
  assign src_addr_o = words[IDX_IADDR];
  assign src_len_o  = words[IDX_ILEN];
  assign dst_addr_o = words[IDX_OADDR];
  assign dst_len_o  = words[IDX_OLEN];
endmodule

// File: tb/cipher_csr_frontend_bench.sv
`timescale 1ns/1ps
module cipher_csr_frontend_bench;
  localparam int LAT = 5;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] key_size_o, mode_o;
  logic encrypt_o, start_o, busy_o;
  logic [255:0] key_o;
  logic [127:0] iv_o;
  logic [31:0] src_addr_o, src_len_o, dst_addr_o, dst_len_o;
  logic core_done_i = 0, core_err_i = 0;
  logic inject_err = 0;
  int n_tests = 0, n_fail = 0, starts = 0, cnt = 0;

  always #2 clk = ~clk;

  cipher_csr_frontend u_cipher_csr_frontend (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_size_o(key_size_o),
    .mode_o(mode_o), .encrypt_o(encrypt_o), .key_o(key_o), .iv_o(iv_o),
    .src_addr_o(src_addr_o), .src_len_o(src_len_o), .dst_addr_o(dst_addr_o),
    .dst_len_o(dst_len_o), .start_o(start_o), .core_done_i(core_done_i),
    .core_err_i(core_err_i), .busy_o(busy_o)
  );

  // fixed-latency datapath stand-in, driven on falling edges
  always @(negedge clk) begin
    core_done_i = 0; core_err_i = 0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        if (inject_err) core_err_i = 1; else core_done_i = 1;
      end
    end
    if (start_o) begin starts = starts + 1; cnt = LAT; end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rd(8'h0C, st);
      if (st[0]) break;
    end
  endtask

  function automatic logic [1:0] exp_ksz(logic [31:0] s);
    return (s[5:4] == 2'b00) ? 2'd0 : (s[5:4] == 2'b01) ? 2'd1 : 2'd2;
  endfunction
  function automatic logic [1:0] exp_mode(logic [31:0] s);
    return (s[3] == 1'b0) ? 2'd0 : (s[2] == 1'b0) ? 2'd1 : 2'd2;
  endfunction
  function automatic logic exp_ok(logic [31:0] kt, logic [31:0] kti, logic [31:0] il,
                                  logic [31:0] ia, logic [31:0] xl, logic [31:0] xa,
                                  logic [31:0] al);
    return (kt == ~kti) && (xl == il) && (al == il) && (xa == ia);
  endfunction

  task automatic cfg(logic [31:0] kt, logic [31:0] kti, logic [31:0] il, logic [31:0] ia,
                     logic [31:0] xl, logic [31:0] xa, logic [31:0] al);
    wr(8'h6C, kt); wr(8'h88, kti); wr(8'h24, il); wr(8'h28, ia);
    wr(8'h2C, xl); wr(8'h30, xa); wr(8'h34, al);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_tests++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, st, s;
    int s0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd(8'h0C, d); chk("R9 reset status", d, 32'hC);
    chk("R12 reset busy", {31'd0, busy_o}, 0);
    rd(8'h84, d); chk("R10 fixed reset", d, 32'hF);
    rd(8'h20, d); chk("R1 reset zero", d, 0);

    // R1 readback
    wr(8'h00, 32'hA5A5_0001); rd(8'h00, d); chk("R1 ctrl", d, 32'hA5A5_0001);
    wr(8'h20, 32'h1000_0040); rd(8'h20, d); chk("R1 dst addr", d, 32'h1000_0040);
    chk("R1 dst addr port", dst_addr_o, 32'h1000_0040);
    wr(8'h70, 32'hDEAD_BEEF); rd(8'h70, d); chk("R1 op word", d, 32'hDEAD_BEEF);
    wr(8'h04, 32'hFFFF_FFFE); rd(8'h04, d); chk("R1 go reads zero", d, 0);
    rd(8'h44, d); chk("R1 unmapped zero", d, 0);

    // R10 fixed / ignored words
    wr(8'h84, 32'h1234_5678); rd(8'h84, d); chk("R10 fixed ignores", d, 32'hF);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R10 0x10 zero", d, 0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R10 0x1C zero", d, 0);

    // R9 status write behaviour
    wr(8'h0C, 32'hFFFF_FFEA); rd(8'h0C, d); chk("R9 upper/ro ignored", d, 32'hC);
    wr(8'h0C, 32'h4); rd(8'h0C, d); chk("R9 clear attention", d, 32'h8);

    // R2/R3 exhaustive setup decode
    for (int v = 0; v < 64; v++) begin
      s = 32'hFFFF_FFC0 | v;
      wr(8'h14, s);
      rd(8'h14, d); chk("R3 setup readback", d, v);
      chk("R2 key size", {30'd0, key_size_o}, exp_ksz(s));
      chk("R3 mode", {30'd0, mode_o}, exp_mode(s));
      chk("R3 direction", {31'd0, encrypt_o}, s[0]);
    end

    // R4 key/IV ordering
    for (int i = 0; i < 8; i++) wr(8'h4C + 8'(4*i), 32'h1111_0000 + i);
    for (int i = 0; i < 4; i++) wr(8'h74 + 8'(4*i), 32'h2222_0000 + i);
    for (int i = 0; i < 8; i++) chk("R4 key word", key_o[255-32*i -: 32], 32'h1111_0000 + i);
    for (int i = 0; i < 4; i++) chk("R4 iv word", iv_o[127-32*i -: 32], 32'h2222_0000 + i);

    // R8 comparison flag
    wr(8'h18, 32'd100); wr(8'h24, 32'd64); rd(8'h40, d); chk("R8 out>in", d, 1);
    wr(8'h18, 32'd64); rd(8'h40, d); chk("R8 out==in", d, 0);

    // valid configuration
    cfg(32'h5, ~32'h5, 32'd64, 32'h2000, 32'd64, 32'h2000, 32'd64);
    s0 = starts;
    wr(8'h04, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    chk("R5 go bit0 clear", {31'd0, busy_o}, 0);
    chk("R5 no start", starts, s0);

    wr(8'h04, 32'h1);
    chk("R12 not yet busy", {31'd0, busy_o}, 0);
    @(negedge clk);
    chk("R12 start pulse", {31'd0, start_o}, 1);
    chk("R12 busy", {31'd0, busy_o}, 1);
    rd(8'h0C, d); chk("R12 status busy", d, 32'hA);
    wr(8'h04, 32'h1);  // R13 go while busy
    wait_done(st);
    chk("R12 done status", st, 32'h9);
    repeat (LAT + 3) @(negedge clk);
    chk("R13 single start", starts, s0 + 1);

    // R12 done gate
    wr(8'h04, 32'h1);
    repeat (3) @(negedge clk);
    chk("R12 held by done", {31'd0, busy_o}, 0);
    wr(8'h0C, 32'h1);
    @(negedge clk);
    chk("R12 launch after clear", {31'd0, busy_o}, 1);
    wait_done(st); wr(8'h0C, 32'h1F);

    // R11 hold
    wr(8'h08, 32'h1);
    wr(8'h04, 32'h1);
    repeat (4) @(negedge clk);
    chk("R11 held", {31'd0, busy_o}, 0);
    wr(8'h08, 32'h0);
    @(negedge clk);
    chk("R11 released", {31'd0, busy_o}, 1);
    wait_done(st); wr(8'h0C, 32'h1F);

    // R6 key type mismatch
    s0 = starts;
    wr(8'h88, 32'h5);
    wr(8'h04, 32'h1); @(negedge clk);
    rd(8'h0C, d); chk("R6 error flag", d, 32'h18);
    chk("R6 no start", starts, s0);
    wr(8'h0C, 32'h10); rd(8'h0C, d); chk("R9 clear error", d, 32'h8);
    wr(8'h88, ~32'h5);

    // R7 descriptor mismatches
    wr(8'h2C, 32'd63);
    wr(8'h04, 32'h1); @(negedge clk);
    rd(8'h0C, d); chk("R7 aux length", d, 32'h18);
    wr(8'h0C, 32'h10); wr(8'h2C, 32'd64); wr(8'h30, 32'h2004);
    wr(8'h04, 32'h1); @(negedge clk);
    rd(8'h0C, d); chk("R7 aux address", d, 32'h18);
    chk("R7 no busy", {31'd0, busy_o}, 0);
    wr(8'h0C, 32'h10); wr(8'h30, 32'h2000);

    // R12 datapath error
    inject_err = 1;
    wr(8'h04, 32'h1);
    wait_done(st);
    chk("R12 core error", st, 32'h19);
    inject_err = 0;
    wr(8'h0C, 32'h1F);

    // constrained random configurations
    for (int it = 0; it < 40; it++) begin
      logic [31:0] kt, kti, il, ia, xl, xa, al, set;
      logic ok;
      set = $urandom; kt = $urandom;
      kti = ($urandom_range(0, 3) != 0) ? ~kt : $urandom;
      il = $urandom_range(1, 4096); ia = $urandom;
      xl = ($urandom_range(0, 4) != 0) ? il : il + 1;
      xa = ($urandom_range(0, 4) != 0) ? ia : ia ^ 32'h10;
      al = ($urandom_range(0, 4) != 0) ? il : il - 1;
      ok = exp_ok(kt, kti, il, ia, xl, xa, al);
      wr(8'h14, set);
      chk("R2 rand key size", {30'd0, key_size_o}, exp_ksz(set));
      chk("R3 rand mode", {30'd0, mode_o}, exp_mode(set));
      cfg(kt, kti, il, ia, xl, xa, al);
      wr(8'h04, 32'h1); @(negedge clk);
      chk(ok ? "R12 rand busy" : "R7 rand busy", {31'd0, busy_o}, {31'd0, ok});
      if (ok) begin
        wait_done(st); chk("R12 rand done", st, 32'h9);
      end else begin
        rd(8'h0C, d); chk("R6 rand error", d, 32'h18);
      end
      wr(8'h0C, 32'h1F);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule